// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models the write-command side of a byte-wide parallel NOR flash. It watches single-cycle bus writes and recognises the multi-write command sequences. Each sequence opens with two unlock writes. The commands are program, chip erase, electronic identification and read/reset. Program and chip erase run against a small internal cell array split into equal sectors, and each sector can be locked by a level input. The time an embedded operation takes is set by cycle-count parameters instead of real pulse timing.

A host starts an operation by writing the full sequence. While an operation runs, the block reports busy and ignores every write. Programming only clears bits, so writing a 1 over a stored 0 leaves a sticky failure indication that only a read/reset write or a hardware reset removes. A read-select output and a combinational read port show array contents, identification codes or a status byte, depending on the current mode. A level input marks the device as being in erase-suspend. In that mode the block returns to suspend, not to plain read, after a program ends or is aborted.

Top module: `flash_cmd_fsm`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the sequence decoder, any running operation, the failure flag and identification mode. After it, busy and fail_flag are 0 and read_sel is 0, or 3 when suspend_in is high. Array contents are kept.
- R2: The writes 0x555/0xAA, 0x2AA/0x55 and 0x555/0xA0, followed by one data write at any address, start a program. busy is high for the PROG_CYC cycles after the data write. The target byte then holds old AND new, and read_sel returns to its home value (0, or 3 in suspend).
- R3: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55 and 0x555/0x10 start a chip erase. At the final write's edge, every unlocked byte becomes 0x00. busy stays high for 2*ERASE_CYC cycles, after which every unlocked byte reads 0xFF.
- R4: Bytes in a sector whose sector_lock bit is set (sector = top SEC_W address bits) are changed by neither program nor erase. A program aimed at a locked sector raises no failure.
- R5: A write of data 0xF0 at any address, in any step of a sequence (including the program data slot), returns the decoder to its start. So does any write that does not match the expected step. No operation starts in either case.
- R6: With suspend_in high, the home mode is 3 (array data) and program sequences are accepted. Erase and identification sequences are rejected.
- R7: While busy is high, all writes are ignored, including 0xF0 and complete command sequences.
- R8: A program that tries to turn a stored 0 into a 1 in an unlocked sector leaves the byte at old AND new. At completion it sets fail_flag with busy low.
- R9: fail_flag stays set until a write with data 0xF0 or a hardware reset. Other writes are ignored while it is set.
- R10: The writes 0x555/0xAA, 0x2AA/0x55 and 0x555/0x90 enter identification mode (read_sel 1). rd_data is then MFR_CODE at even rd_addr and DEV_CODE at odd rd_addr. Only a write with data 0xF0 leaves this mode.
- R11: A hardware reset during a program leaves the target byte unchanged.
- R12: read_sel is 2 whenever busy or fail_flag is set. rd_data is then the status byte, with bit 7 = busy, bit 5 = fail_flag and every other bit 0.
- R13: read_sel encodes 0 = array data, 1 = identification codes, 2 = status byte, 3 = array data in erase-suspend. Busy, failure and identification mode are mutually exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| bus_we | input | 1 | One-cycle write strobe |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 8 | Write data |
| rd_addr | input | ARR_AW | Read address |
| rd_data | output | 8 | Read data selected by read_sel |
| suspend_in | input | 1 | Device is in erase-suspend |
| sector_lock | input | 2**SEC_W | Per-sector lock bits |
| busy | output | 1 | Embedded operation running |
| fail_flag | output | 1 | Program tried to set a cleared bit |
| read_sel | output | 2 | Current read mode |

## Verification
The properties assume that bus_we lasts one cycle per write, and that sector_lock and suspend_in change only while no operation runs. They also assume the reset is held for at least one clock edge, so the cycle after a reset is excluded from the transition checks. The stimulus follows these assumptions: it changes the lock and suspend levels only after busy has dropped, and it drives each write for exactly one clock. A behavioural model in the bench tracks the sequence step, the operation countdown and every array byte it knows. Against that model, busy, fail_flag, read_sel and rd_data are compared every cycle.

// File: rtl/flash_cmd_pkg.sv
// Package: shared types and command codes of the flash command sequencer.
// Assumes byte-wide command data and 11-bit command address matching.
package flash_cmd_pkg;

    localparam int DW = 8;

    localparam logic [DW-1:0] CMD_RESET  = 8'hF0;
    localparam logic [DW-1:0] CMD_UNLK_A = 8'hAA;
    localparam logic [DW-1:0] CMD_UNLK_B = 8'h55;
    localparam logic [DW-1:0] CMD_PROG   = 8'hA0;
    localparam logic [DW-1:0] CMD_ERASE  = 8'h80;
    localparam logic [DW-1:0] CMD_CHIP   = 8'h10;
    localparam logic [DW-1:0] CMD_IDENT  = 8'h90;

    localparam logic [10:0] ADR_UNLK_A = 11'h555;
    localparam logic [10:0] ADR_UNLK_B = 11'h2AA;

    // Sequence decoder step
    typedef enum logic [2:0] {
        SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PSETUP, SQ_ERS1, SQ_ERS2, SQ_ERS3
    } seq_t;

    // Embedded operation phase
    typedef enum logic [2:0] {
        OP_IDLE, OP_PROG, OP_PRE, OP_ERASE, OP_FAIL
    } op_t;

    // Read mode as seen on read_sel
    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_IDENT  = 2'd1,
        MD_STATUS = 2'd2,
        MD_SUSP   = 2'd3
    } mode_t;

endpackage

// File: rtl/fcs_seq_decoder.sv
// Module: command sequence decoder.
// Tracks the unlock/command write steps and emits one-cycle start pulses for
// program, chip erase and identification. Assumes 'listen' is low whenever an
// operation runs, a failure is pending, identification mode is active or reset
// is asserted; while low the decoder holds its step.
module fcs_seq_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              listen,
    input  logic              home_susp,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     data,
    output logic              go_prog,
    output logic              go_erase,
    output logic              go_ident,
    output logic              seq_idle
);

    seq_t step_q, step_d;
    logic at_a, at_b;

    assign at_a = (addr == ADDR_W'(ADR_UNLK_A));
    assign at_b = (addr == ADDR_W'(ADR_UNLK_B));

    // Next step and start pulses from the current step and the write
    always_comb begin
        step_d   = step_q;
        go_prog  = 1'b0;
        go_erase = 1'b0;
        go_ident = 1'b0;
        if (listen && we) begin
            if (data == CMD_RESET) begin
                step_d = SQ_IDLE;
            end else begin
                case (step_q)
                    SQ_IDLE:   step_d = (at_a && data == CMD_UNLK_A) ? SQ_UNL1 : SQ_IDLE;
                    SQ_UNL1:   step_d = (at_b && data == CMD_UNLK_B) ? SQ_UNL2 : SQ_IDLE;
                    SQ_UNL2: begin
                        step_d = SQ_IDLE;
                        if (at_a && data == CMD_PROG) begin
                            step_d = SQ_PSETUP;
                        end else if (at_a && data == CMD_ERASE && !home_susp) begin
                            step_d = SQ_ERS1;
                        end else if (at_a && data == CMD_IDENT && !home_susp) begin
                            go_ident = 1'b1;
                        end
                    end
                    SQ_PSETUP: begin
                        go_prog = 1'b1;
                        step_d  = SQ_IDLE;
                    end
                    SQ_ERS1:   step_d = (at_a && data == CMD_UNLK_A) ? SQ_ERS2 : SQ_IDLE;
                    SQ_ERS2:   step_d = (at_b && data == CMD_UNLK_B) ? SQ_ERS3 : SQ_IDLE;
                    SQ_ERS3: begin
                        go_erase = at_a && (data == CMD_CHIP);
                        step_d   = SQ_IDLE;
                    end
                    default:   step_d = SQ_IDLE;
                endcase
            end
        end
    end

    // Step register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= SQ_IDLE;
        else        step_q <= step_d;
    end

    assign seq_idle = (step_q == SQ_IDLE);

endmodule

// File: rtl/fcs_op_engine.sv
// Module: embedded operation engine.
// Times program (PROG_CYC cycles) and chip erase (preprogram phase then erase
// phase, ERASE_CYC cycles each) and holds the failure state. Assumes start
// pulses arrive only while idle. The array is updated by the strobes it emits:
// zero_en at erase start, prog_en and ones_en at the end of their phase.
module fcs_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int ARR_AW    = 6,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_prog,
    input  logic              go_erase,
    input  logic [ARR_AW-1:0] start_addr,
    input  logic [DW-1:0]     start_data,
    input  logic              we,
    input  logic [DW-1:0]     data,
    input  logic              prog_fail,
    output logic              busy,
    output logic              fail,
    output logic [ARR_AW-1:0] tgt_addr,
    output logic [DW-1:0]     tgt_data,
    output logic              prog_en,
    output logic              zero_en,
    output logic              ones_en
);

    localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    op_t              op_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q == '0);

    // Phase sequencing and countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_IDLE;
            cnt_q    <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
        end else begin
            case (op_q)
                OP_IDLE: begin
                    if (go_prog) begin
                        op_q     <= OP_PROG;
                        cnt_q    <= CNT_W'(PROG_CYC - 1);
                        tgt_addr <= start_addr;
                        tgt_data <= start_data;
                    end else if (go_erase) begin
                        op_q  <= OP_PRE;
                        cnt_q <= CNT_W'(ERASE_CYC - 1);
                    end
                end
                OP_PROG: begin
                    if (last) op_q <= prog_fail ? OP_FAIL : OP_IDLE;
                    else      cnt_q <= cnt_q - 1'b1;
                end
                OP_PRE: begin
                    if (last) begin
                        op_q  <= OP_ERASE;
                        cnt_q <= CNT_W'(ERASE_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                OP_ERASE: begin
                    if (last) op_q <= OP_IDLE;
                    else      cnt_q <= cnt_q - 1'b1;
                end
                OP_FAIL: begin
                    if (we && data == CMD_RESET) op_q <= OP_IDLE;
                end
                default: op_q <= OP_IDLE;
            endcase
        end
    end

    // Array strobes and flags from the current phase
    always_comb begin
        busy    = (op_q == OP_PROG) || (op_q == OP_PRE) || (op_q == OP_ERASE);
        fail    = (op_q == OP_FAIL);
        prog_en = (op_q == OP_PROG) && last;
        zero_en = (op_q == OP_IDLE) && go_erase;
        ones_en = (op_q == OP_ERASE) && last;
    end

endmodule

// File: rtl/fcs_array.sv
// Module: sectored cell array.
// Holds 2**ARR_AW bytes in 2**SEC_W equal sectors with no reset, like real
// cells. Program ANDs new data into a byte; zero/ones strobes act on all
// unlocked bytes. Assumes sector_lock is stable while an operation runs.
module fcs_array
    import flash_cmd_pkg::*;
#(
    parameter int ARR_AW = 6,
    parameter int SEC_W  = 2
) (
    input  logic                   clk,
    input  logic [(1<<SEC_W)-1:0]  sector_lock,
    input  logic                   prog_en,
    input  logic [ARR_AW-1:0]      prog_addr,
    input  logic [DW-1:0]          prog_data,
    input  logic                   zero_en,
    input  logic                   ones_en,
    input  logic [ARR_AW-1:0]      rd_addr,
    output logic [DW-1:0]          rd_word,
    output logic                   prog_fail
);

    localparam int DEPTH     = 1 << ARR_AW;
    localparam int SEC_SHIFT = ARR_AW - SEC_W;

    logic [DW-1:0] cells [DEPTH];
    logic          tgt_locked;

    // Per-byte update under the sector lock
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!sector_lock[SEC_W'(i >> SEC_SHIFT)]) begin
                if (ones_en)
                    cells[i] <= '1;
                else if (zero_en)
                    cells[i] <= '0;
                else if (prog_en && prog_addr == ARR_AW'(i))
                    cells[i] <= cells[i] & prog_data;
            end
        end
    end

    // Failure detect: a 1 requested where an unlocked cell holds 0
    always_comb begin
        tgt_locked = sector_lock[prog_addr[ARR_AW-1 -: SEC_W]];
        prog_fail  = !tgt_locked && (|(prog_data & ~cells[prog_addr]));
        rd_word    = cells[rd_addr];
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
// Module: top of the flash command sequencer.
// Joins decoder, operation engine and array, keeps identification mode and
// selects read data. Assumes one-cycle write strobes and that suspend_in and
// sector_lock change only while no operation is running.
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W    = 11,
    parameter int          ARR_AW    = 6,
    parameter int          SEC_W     = 2,
    parameter int          PROG_CYC  = 8,
    parameter int          ERASE_CYC = 12,
    parameter logic [7:0]  MFR_CODE  = 8'hC5,
    parameter logic [7:0]  DEV_CODE  = 8'h3A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [7:0]            bus_wdata,
    input  logic [ARR_AW-1:0]     rd_addr,
    output logic [7:0]            rd_data,
    input  logic                  suspend_in,
    input  logic [(1<<SEC_W)-1:0] sector_lock,
    output logic                  busy,
    output logic                  fail_flag,
    output logic [1:0]            read_sel
);

    logic              listen, seq_idle, id_mode;
    logic              go_prog, go_erase, go_ident;
    logic [ARR_AW-1:0] tgt_addr;
    logic [DW-1:0]     tgt_data, rd_word;
    logic              prog_en, zero_en, ones_en, prog_fail;
    mode_t             mode;

    assign listen = rst_n && !busy && !fail_flag && !id_mode;

    fcs_seq_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .listen   (listen),
        .home_susp(suspend_in),
        .we       (bus_we),
        .addr     (bus_addr),
        .data     (bus_wdata),
        .go_prog  (go_prog),
        .go_erase (go_erase),
        .go_ident (go_ident),
        .seq_idle (seq_idle)
    );

    fcs_op_engine #(
        .ARR_AW   (ARR_AW),
        .PROG_CYC (PROG_CYC),
        .ERASE_CYC(ERASE_CYC)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_prog   (go_prog),
        .go_erase  (go_erase),
        .start_addr(bus_addr[ARR_AW-1:0]),
        .start_data(bus_wdata),
        .we        (bus_we),
        .data      (bus_wdata),
        .prog_fail (prog_fail),
        .busy      (busy),
        .fail      (fail_flag),
        .tgt_addr  (tgt_addr),
        .tgt_data  (tgt_data),
        .prog_en   (prog_en),
        .zero_en   (zero_en),
        .ones_en   (ones_en)
    );

    fcs_array #(.ARR_AW(ARR_AW), .SEC_W(SEC_W)) u_arr (
        .clk        (clk),
        .sector_lock(sector_lock),
        .prog_en    (prog_en),
        .prog_addr  (tgt_addr),
        .prog_data  (tgt_data),
        .zero_en    (zero_en),
        .ones_en    (ones_en),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word),
        .prog_fail  (prog_fail)
    );

    // Identification mode: entered by its sequence, left by a reset write
    always_ff @(posedge clk) begin
        if (!rst_n)                                   id_mode <= 1'b0;
        else if (go_ident)                            id_mode <= 1'b1;
        else if (id_mode && bus_we && bus_wdata == CMD_RESET) id_mode <= 1'b0;
    end

    // Mode selection and read multiplexer
    always_comb begin
        if (busy || fail_flag) mode = MD_STATUS;
        else if (id_mode)      mode = MD_IDENT;
        else if (suspend_in)   mode = MD_SUSP;
        else                   mode = MD_ARRAY;
        case (mode)
            MD_STATUS: rd_data = {busy, 1'b0, fail_flag, 5'b0};
            MD_IDENT:  rd_data = rd_addr[0] ? DEV_CODE : MFR_CODE;
            default:   rd_data = rd_word;
        endcase
        read_sel = mode;
    end

endmodule

// File: rtl/flash_cmd_fsm_chk.sv
// Module: property checker bound to flash_cmd_fsm.
// Assumes one-cycle write strobes; transitions in the cycle after a reset are
// excluded through the past value of rst_n.
module flash_cmd_fsm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic       busy,
    input logic       fail_flag,
    input logic [1:0] read_sel,
    input logic       seq_idle,
    input logic       id_mode
);

    // R7
    busy_blocks_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> seq_idle);

    // R12
    status_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || fail_flag) |-> read_sel == 2'd2);

    // R8
    fail_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_flag |-> !busy);

    // R9
    fail_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fail_flag) && $past(rst_n)) |-> $past(bus_we && bus_wdata == 8'hF0));

    // R10
    ident_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(read_sel) == 2'd1 && read_sel != 2'd1)
        |-> $past(bus_we && bus_wdata == 8'hF0));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(rst_n)) |-> $past(bus_we));

    // R13
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, fail_flag, id_mode}));

endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .busy     (busy),
    .fail_flag(fail_flag),
    .read_sel (read_sel),
    .seq_idle (seq_idle),
    .id_mode  (id_mode)
);

// File: tb/test_flash_cmd_fsm.sv
`timescale 1ns/1ps
module test_flash_cmd_fsm;

    localparam int PC = 8;
    localparam int EC = 12;
    localparam logic [7:0] MFR = 8'hC5;
    localparam logic [7:0] DEV = 8'h3A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [5:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        suspend_in = 1'b0;
    logic [3:0]  sector_lock = '0;
    logic        busy, fail_flag;
    logic [1:0]  read_sel;

    int checks = 0;
    int errors = 0;

    flash_cmd_fsm i_flash_cmd_fsm (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .suspend_in(suspend_in), .sector_lock(sector_lock), .busy(busy),
        .fail_flag(fail_flag), .read_sel(read_sel)
    );

    always #2 clk = ~clk;

    // Reference model state: step, operation (0 none,1 prog,2 pre,3 erase,4 fail)
    int         m_step = 0, m_op = 0, m_cnt = 0;
    bit         m_id = 0;
    logic [7:0] m_mem [64];
    bit         m_known [64];
    int         m_pa = 0;
    logic [7:0] m_pd = '0;

    function automatic bit locked(int a);
        return sector_lock[a / 16];
    endfunction

    // Model step on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0; m_op = 0; m_id = 0;
        end else if (m_op == 1) begin
            if (m_cnt == 0) begin
                if (!locked(m_pa) && ((m_pd & ~m_mem[m_pa]) != 8'h00)) m_op = 4;
                else m_op = 0;
                if (!locked(m_pa)) m_mem[m_pa] = m_mem[m_pa] & m_pd;
            end else m_cnt--;
        end else if (m_op == 2) begin
            if (m_cnt == 0) begin m_op = 3; m_cnt = EC - 1; end else m_cnt--;
        end else if (m_op == 3) begin
            if (m_cnt == 0) begin
                m_op = 0;
                for (int i = 0; i < 64; i++)
                    if (!locked(i)) begin m_mem[i] = 8'hFF; m_known[i] = 1; end
            end else m_cnt--;
        end else if (m_op == 4) begin
            if (bus_we && bus_wdata == 8'hF0) m_op = 0;
        end else if (m_id) begin
            if (bus_we && bus_wdata == 8'hF0) m_id = 0;
        end else if (bus_we) begin
            if (bus_wdata == 8'hF0) m_step = 0;
            else begin
                case (m_step)
                    0: m_step = (bus_addr == 11'h555 && bus_wdata == 8'hAA) ? 1 : 0;
                    1: m_step = (bus_addr == 11'h2AA && bus_wdata == 8'h55) ? 2 : 0;
                    2: begin
                        m_step = 0;
                        if (bus_addr == 11'h555) begin
                            if (bus_wdata == 8'hA0) m_step = 3;
                            else if (bus_wdata == 8'h80 && !suspend_in) m_step = 4;
                            else if (bus_wdata == 8'h90 && !suspend_in) m_id = 1;
                        end
                    end
                    3: begin
                        m_step = 0; m_op = 1; m_cnt = PC - 1;
                        m_pa = int'(bus_addr[5:0]); m_pd = bus_wdata;
                    end
                    4: m_step = (bus_addr == 11'h555 && bus_wdata == 8'hAA) ? 5 : 0;
                    5: m_step = (bus_addr == 11'h2AA && bus_wdata == 8'h55) ? 6 : 0;
                    6: begin
                        m_step = 0;
                        if (bus_addr == 11'h555 && bus_wdata == 8'h10) begin
                            m_op = 2; m_cnt = EC - 1;
                            for (int i = 0; i < 64; i++)
                                if (!locked(i)) begin m_mem[i] = 8'h00; m_known[i] = 1; end
                        end
                    end
                    default: m_step = 0;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle compare against the model
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            logic [1:0] e_sel;
            logic       e_busy, e_fail;
            e_busy = (m_op >= 1 && m_op <= 3);
            e_fail = (m_op == 4);
            e_sel  = (e_busy || e_fail) ? 2'd2 : m_id ? 2'd1 : suspend_in ? 2'd3 : 2'd0;
            chk("R7 model busy", {7'b0, busy}, {7'b0, e_busy});
            chk("R9 model fail_flag", {7'b0, fail_flag}, {7'b0, e_fail});
            chk("R13 model read_sel", {6'b0, read_sel}, {6'b0, e_sel});
            if (e_sel == 2'd2)      chk("R12 model status", rd_data, {e_busy, 1'b0, e_fail, 5'b0});
            else if (e_sel == 2'd1) chk("R10 model ident", rd_data, rd_addr[0] ? DEV : MFR);
            else if (m_known[rd_addr]) chk("R2 model array", rd_data, m_mem[rd_addr]);
        end
    end

    task automatic wr(logic [10:0] a, logic [7:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask
    task automatic unlock();
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
    endtask
    task automatic prog(logic [10:0] a, logic [7:0] d);
        unlock(); wr(11'h555, 8'hA0); wr(a, d);
    endtask
    task automatic erase();
        unlock(); wr(11'h555, 8'h80); unlock(); wr(11'h555, 8'h10);
    endtask
    task automatic wait_idle();
        for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    endtask
    task automatic rd(logic [5:0] a, logic [7:0] exp, string tag);
        @(negedge clk); rd_addr = a; #1; chk(tag, rd_data, exp);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset busy", {7'b0, busy}, 8'h00);
        chk("R1 reset fail", {7'b0, fail_flag}, 8'h00);
        chk("R1 reset read_sel", {6'b0, read_sel}, 8'h00);

        erase();
        chk("R3 erase busy", {7'b0, busy}, 8'h01);
        wait_idle();
        rd(6'h00, 8'hFF, "R3 erased low");
        rd(6'h3F, 8'hFF, "R3 erased high");

        prog(11'h005, 8'h3C);
        chk("R12 status while programming", {6'b0, read_sel}, 8'h02);
        wait_idle();
        chk("R2 read_sel home", {6'b0, read_sel}, 8'h00);
        rd(6'h05, 8'h3C, "R2 programmed");

        prog(11'h006, 8'hA5);
        wr(11'h000, 8'hF0);
        prog(11'h007, 8'h00);
        wait_idle();
        rd(6'h06, 8'hA5, "R7 program survives writes");
        rd(6'h07, 8'hFF, "R7 sequence while busy ignored");

        prog(11'h005, 8'h43);
        wait_idle();
        chk("R8 fail set", {7'b0, fail_flag}, 8'h01);
        rd(6'h05, 8'h20, "R12 status byte on fail");
        wr(11'h555, 8'hAA);
        chk("R9 fail held", {7'b0, fail_flag}, 8'h01);
        wr(11'h000, 8'hF0);
        chk("R9 fail cleared", {7'b0, fail_flag}, 8'h00);
        rd(6'h05, 8'h00, "R8 stored AND");

        unlock(); wr(11'h555, 8'hF0);
        wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h009, 8'h00);
        rd(6'h09, 8'hFF, "R5 abort after unlock");
        unlock(); wr(11'h555, 8'hA0); wr(11'h00A, 8'hF0);
        chk("R5 abort in data slot", {7'b0, busy}, 8'h00);
        unlock(); wr(11'h555, 8'h77); wr(11'h00B, 8'h00);
        rd(6'h0B, 8'hFF, "R5 wrong command");

        suspend_in = 1'b1;
        @(negedge clk);
        chk("R6 suspend home", {6'b0, read_sel}, 8'h03);
        unlock(); wr(11'h555, 8'hA0); wr(11'h000, 8'hF0);
        chk("R6 abort back to suspend", {6'b0, read_sel}, 8'h03);
        erase();
        chk("R6 erase rejected", {7'b0, busy}, 8'h00);
        prog(11'h00C, 8'h5A);
        wait_idle();
        rd(6'h0C, 8'h5A, "R6 program in suspend");
        chk("R6 after program", {6'b0, read_sel}, 8'h03);
        suspend_in = 1'b0;

        unlock(); wr(11'h555, 8'h90);
        chk("R10 ident mode", {6'b0, read_sel}, 8'h01);
        rd(6'h00, MFR, "R10 maker code");
        rd(6'h01, DEV, "R10 device code");
        wr(11'h555, 8'hAA);
        chk("R10 ident held", {6'b0, read_sel}, 8'h01);
        wr(11'h000, 8'hF0);
        chk("R10 ident left", {6'b0, read_sel}, 8'h00);

        prog(11'h012, 8'h00);
        wait_idle();
        sector_lock = 4'b0010;
        erase();
        wait_idle();
        rd(6'h12, 8'h00, "R4 locked sector kept by erase");
        rd(6'h05, 8'hFF, "R4 unlocked sector erased");
        prog(11'h012, 8'h77);
        wait_idle();
        chk("R4 no fail on locked", {7'b0, fail_flag}, 8'h00);
        rd(6'h12, 8'h00, "R4 locked program ignored");
        sector_lock = 4'b0000;
        @(negedge clk);

        prog(11'h020, 8'h00);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset ends busy", {7'b0, busy}, 8'h00);
        rd(6'h20, 8'hFF, "R11 reset mid-program");

        erase();
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(6'h00, 8'h00, "R3 preprogram zeros");
        rd(6'h30, 8'h00, "R3 preprogram zeros high");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule